// File: doc/BRIEF.md
# Packet DMA Scheduler

This block moves whole packets of a fixed length between a packet FIFO and a word-wide memory port. It has one transfer engine. The engine serves either a receive transfer or a transmit transfer. A receive transfer pops words from the FIFO and writes them to memory. A transmit transfer reads words from memory and pushes them into the FIFO.

A receive starts in hardware. It starts when the receive-side almost-empty flag shows that a full packet is waiting and the receive trigger is armed. A transmit starts when software raises a request and the transmit-side almost-full flag shows room for a whole packet. The flags already guarantee the data or the space for the whole packet, so there is no handshake per word. The engine loads a word counter with the packet length. The counter drops by one for every acknowledged memory word. When it reaches zero, the block pulses a completion interrupt.

Requests that arrive while the engine is busy are not lost. A receive trigger is parked in a single slot. Transmit requests go into a four-entry ring, which is also used when the FIFO has no room. In the cycle after completion, the scheduler serves work in a fixed order. A parked receive comes first, then a newly ready packet, then the oldest queued transmit.

Top module: `pkt_dma_sched`

## Requirements
- R1: After reset, mem_req, done_irq and tx_ovf are low and rx_armed is high.
- R2: Each transfer moves exactly PKT_WORDS words. mem_req stays high with mem_addr unchanged until mem_ack. done_irq is a one-cycle pulse in the cycle after the last acknowledged word, with mem_req low in that cycle.
- R3: A receive transfer drives mem_we=1, starts at its destination address and pulses fifo_rd once per acknowledged word.
- R4: A transmit transfer drives mem_we=0, starts at its source address and pulses fifo_wr once per acknowledged word.
- R5: The dec bit captured with a transfer selects the step. dec=0 adds 1 to the address after each word and dec=1 subtracts 1.
- R6: While idle, rx_almost_empty_n high with rx_armed high starts a receive to rx_dst_addr. Any accepted trigger clears rx_armed in the next cycle.
- R7: A receive trigger that arrives during a transfer parks rx_dst_addr and rx_dst_dec in a one-entry slot. It starts nothing until the current transfer completes.
- R8: While idle with an empty queue, tx_req with tx_almost_full_n high starts a transmit from tx_src_addr at once. Otherwise the request is queued, and queued requests run in arrival order.
- R9: The transmit queue holds 4 entries. A request made while the queue is full is dropped and tx_ovf pulses for one cycle. The entries already queued are kept.
- R10: In the cycle after completion, the scheduler first serves a parked receive. If there is none, it serves a receive when rx_almost_empty_n is high. If neither applies, it serves the queue head when tx_almost_full_n is high.
- R11: At completion with no parked receive and rx_almost_empty_n low, rx_armed is set again.
- R12: While idle and not starting a receive, a non-empty queue with tx_almost_full_n high starts its head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_almost_empty_n | input | 1 | Receive FIFO almost-empty flag, active low; high means a full packet is queued |
| tx_almost_full_n | input | 1 | Transmit FIFO almost-full flag, active low; high means room for a packet |
| rx_dst_addr | input | AW | Memory destination base for the next receive |
| rx_dst_dec | input | 1 | Step direction for the next receive (1 = decrement) |
| tx_req | input | 1 | One-cycle transmit request |
| tx_src_addr | input | AW | Memory source base for the request |
| tx_src_dec | input | 1 | Step direction for the request (1 = decrement) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write (receive), 0 = memory read (transmit) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data to memory |
| mem_rdata | input | DW | Read data from memory |
| mem_ack | input | 1 | Memory accepts the current word |
| fifo_rd | output | 1 | Pop strobe to the receive FIFO |
| fifo_rdata | input | DW | Receive FIFO head word |
| fifo_wr | output | 1 | Push strobe to the transmit FIFO |
| fifo_wdata | output | DW | Word pushed to the transmit FIFO |
| rx_armed | output | 1 | Receive trigger enable |
| done_irq | output | 1 | Completion pulse |
| tx_ovf | output | 1 | Rejected transmit request pulse |

## Verification
The bench builds the block with PKT_WORDS=4, AW=12, DW=16 and QDEPTH=4. A four-word packet is short enough to park a receive trigger and two transmit requests inside one transfer. The bench can fill the ring to overflow and then drain it within a few dozen cycles. With random acknowledge stalls, each transfer still has to complete in the expected order.

// File: rtl/pkt_dma_sched.sv
module pkt_dma_sched #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int PKT_WORDS = 128,
  parameter int QDEPTH    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_almost_empty_n,
  input  logic          tx_almost_full_n,
  input  logic [AW-1:0] rx_dst_addr,
  input  logic          rx_dst_dec,
  input  logic          tx_req,
  input  logic [AW-1:0] tx_src_addr,
  input  logic          tx_src_dec,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          fifo_rd,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic          rx_armed,
  output logic          done_irq,
  output logic          tx_ovf
);
  localparam int CW  = $clog2(PKT_WORDS + 1);
  localparam int QAW = $clog2(QDEPTH);
  localparam logic [CW-1:0]  PKT_LD = CW'(PKT_WORDS);
  localparam logic [QAW:0]   Q_MAX  = (QAW+1)'(QDEPTH);

  logic [CW-1:0]  cnt;
  logic [AW-1:0]  cur_addr;
  logic           cur_rx, cur_dec;
  logic           done_q, armed;
  logic           pend_v, pend_dec;
  logic [AW-1:0]  pend_addr;
  logic [AW:0]    q_mem [QDEPTH];
  logic [QAW-1:0] q_wp, q_rp;
  logic [QAW:0]   q_cnt;

  wire active  = cnt != '0;
  wire ack_w   = active & mem_ack;
  wire last    = ack_w & (cnt == CW'(1));
  wire idle    = !active & !done_q;
  wire drain   = done_q;
  wire pkt_rdy = rx_almost_empty_n;
  wire room    = tx_almost_full_n;
  wire q_empty = q_cnt == '0;
  wire q_full  = q_cnt == Q_MAX;
  wire rx_trig = armed & pkt_rdy;

  wire s_rx_pend = drain & pend_v;
  wire s_rx_new  = (drain & !pend_v & pkt_rdy) | (idle & rx_trig);
  wire s_tx_q    = !q_empty & room & ((drain & !pend_v & !pkt_rdy) | (idle & !rx_trig));
  wire s_tx_in   = idle & !rx_trig & q_empty & room & tx_req;
  wire start     = s_rx_pend | s_rx_new | s_tx_q | s_tx_in;
  wire park      = rx_trig & active;
  wire enq       = tx_req & !s_tx_in;
  wire pop       = s_tx_q;
  wire enq_ok    = enq & (!q_full | pop);

  logic [AW-1:0] nxt_addr;
  logic          nxt_dec, nxt_rx;

  always_comb begin
    if (s_rx_pend) begin
      nxt_addr = pend_addr; nxt_dec = pend_dec; nxt_rx = 1'b1;
    end else if (s_rx_new) begin
      nxt_addr = rx_dst_addr; nxt_dec = rx_dst_dec; nxt_rx = 1'b1;
    end else if (s_tx_q) begin
      nxt_addr = q_mem[q_rp][AW-1:0]; nxt_dec = q_mem[q_rp][AW]; nxt_rx = 1'b0;
    end else begin
      nxt_addr = tx_src_addr; nxt_dec = tx_src_dec; nxt_rx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      cur_addr  <= '0;
      cur_rx    <= 1'b0;
      cur_dec   <= 1'b0;
      done_q    <= 1'b0;
      armed     <= 1'b1;
      pend_v    <= 1'b0;
      pend_dec  <= 1'b0;
      pend_addr <= '0;
      q_wp      <= '0;
      q_rp      <= '0;
      q_cnt     <= '0;
      tx_ovf    <= 1'b0;
    end else begin
      done_q <= last;
      tx_ovf <= enq & !enq_ok;

      if (start) begin
        cnt      <= PKT_LD;
        cur_addr <= nxt_addr;
        cur_dec  <= nxt_dec;
        cur_rx   <= nxt_rx;
      end else if (ack_w) begin
        cnt      <= cnt - CW'(1);
        cur_addr <= cur_dec ? cur_addr - AW'(1) : cur_addr + AW'(1);
      end

      if (s_rx_pend) begin
        pend_v <= 1'b0;
      end else if (park) begin
        pend_v    <= 1'b1;
        pend_addr <= rx_dst_addr;
        pend_dec  <= rx_dst_dec;
      end

      if (s_rx_new | park)
        armed <= 1'b0;
      else if (drain & !pend_v & !pkt_rdy)
        armed <= 1'b1;

      if (enq_ok) q_wp <= q_wp + QAW'(1);
      if (pop)    q_rp <= q_rp + QAW'(1);
      q_cnt <= q_cnt + (QAW+1)'(enq_ok) - (QAW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (enq_ok) q_mem[q_wp] <= {tx_src_dec, tx_src_addr};
  end

  assign mem_req    = active;
  assign mem_we     = cur_rx;
  assign mem_addr   = cur_addr;
  assign mem_wdata  = fifo_rdata;
  assign fifo_wdata = mem_rdata;
  assign fifo_rd    = ack_w & cur_rx;
  assign fifo_wr    = ack_w & !cur_rx;
  assign done_irq   = done_q;
  assign rx_armed   = armed;
endmodule

// File: rtl/pkt_dma_sched_chk.sv
module pkt_dma_sched_chk #(
  parameter int AW     = 16,
  parameter int QDEPTH = 4,
  parameter int QAW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          fifo_rd,
  input logic          rx_armed,
  input logic          rx_almost_empty_n,
  input logic          done_irq,
  input logic          tx_ovf,
  input logic          pend_v,
  input logic [QAW:0]  q_cnt
);
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_irq |=> !done_irq); // R2
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_irq |-> !mem_req); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
  AST_POP_ON_RX: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |-> (mem_we && mem_req)); // R3
  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_armed && rx_almost_empty_n) |=> !rx_armed); // R6
  AST_SLOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pend_v && rx_armed)); // R7
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> ($past(q_cnt) == (QAW+1)'(QDEPTH))); // R9
  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= (QAW+1)'(QDEPTH)); // R9
endmodule

bind pkt_dma_sched pkt_dma_sched_chk #(.AW(AW), .QDEPTH(QDEPTH), .QAW(QAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .fifo_rd(fifo_rd), .rx_armed(rx_armed),
  .rx_almost_empty_n(rx_almost_empty_n), .done_irq(done_irq), .tx_ovf(tx_ovf),
  .pend_v(pend_v), .q_cnt(q_cnt)
);

// File: tb/pkt_dma_sched_bench.sv
`timescale 1ns/100ps
module pkt_dma_sched_bench;
  localparam int AW = 12, DW = 16, PKT = 4, QD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_ae_n = 1'b0, tx_af_n = 1'b1;
  logic [AW-1:0] rx_dst = '0, tx_src = '0;
  logic rx_dec = 1'b0, tx_dec = 1'b0, tx_req = 1'b0;
  logic mem_req, mem_we, mem_ack, fifo_rd, fifo_wr, rx_armed, done_irq, tx_ovf;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fifo_rdata, fifo_wdata;

  always #2.5 clk = ~clk;

  pkt_dma_sched #(.AW(AW), .DW(DW), .PKT_WORDS(PKT), .QDEPTH(QD)) u_pkt_dma_sched (
    .clk(clk), .rst_n(rst_n), .rx_almost_empty_n(rx_ae_n), .tx_almost_full_n(tx_af_n),
    .rx_dst_addr(rx_dst), .rx_dst_dec(rx_dec), .tx_req(tx_req), .tx_src_addr(tx_src),
    .tx_src_dec(tx_dec), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .fifo_rd(fifo_rd),
    .fifo_rdata(fifo_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .rx_armed(rx_armed), .done_irq(done_irq), .tx_ovf(tx_ovf));

  int n_chk = 0, n_bad = 0, cyc = 0, ack_pct = 100;
  int n_exp = 0, t_idx = 0, w_idx = 0, n_done = 0, n_ovf = 0, n_rd = 0;
  bit prev_done = 1'b0;
  logic [AW-1:0] eb [64];
  bit ed [64], ew [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] step(input logic [AW-1:0] b, input bit d, input int i);
    return d ? b - AW'(i) : b + AW'(i);
  endfunction

  task automatic expect_xfer(input logic [AW-1:0] b, input bit d, input bit we);
    eb[n_exp] = b; ed[n_exp] = d; ew[n_exp] = we; n_exp++;
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    mem_ack    <= (int'($urandom % 100) < ack_pct);
    mem_rdata  <= DW'($urandom);
    fifo_rdata <= DW'($urandom);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        if (t_idx >= n_exp) begin
          chk(1'b0, "R2 unexpected word, addr", int'(mem_addr), -1);
        end else begin
          chk(mem_addr == step(eb[t_idx], ed[t_idx], w_idx), "R3 R4 R5 word address",
              int'(mem_addr), int'(step(eb[t_idx], ed[t_idx], w_idx)));
          chk(mem_we == ew[t_idx] && fifo_rd == ew[t_idx] && fifo_wr == !ew[t_idx],
              "R3 R4 direction strobes", int'(mem_we), int'(ew[t_idx]));
          w_idx++;
          if (w_idx == PKT) begin w_idx = 0; t_idx++; end
        end
      end
      if (fifo_rd) n_rd++;
      if (tx_ovf) n_ovf++;
      if (done_irq) begin
        n_done++;
        if (prev_done) chk(1'b0, "R2 done_irq wider than one cycle", 2, 1);
        if (mem_req) chk(1'b0, "R2 mem_req during done_irq", 1, 0);
      end
      prev_done = done_irq;
    end
  end

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
    finish_up();
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_all;
    int g = 0;
    while ((t_idx < n_exp || mem_req || done_irq) && g < 5000) begin tick(1); g++; end
    tick(2);
    chk(t_idx == n_exp, "R2 transfers completed", t_idx, n_exp);
  endtask

  task automatic pulse_tx(input logic [AW-1:0] a, input bit d);
    tx_src = a; tx_dec = d; tx_req = 1'b1;
    tick(1);
    tx_req = 1'b0;
  endtask

  initial begin
    int d0;
    mem_ack = 1'b1; mem_rdata = '0; fifo_rdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(!mem_req && !done_irq && !tx_ovf, "R1 outputs idle", int'(mem_req), 0);
    chk(rx_armed, "R1 rx_armed after reset", int'(rx_armed), 1);

    // R6 R3: receive from idle
    d0 = n_done;
    expect_xfer(12'h100, 1'b0, 1'b1);
    rx_dst = 12'h100; rx_dec = 1'b0; rx_ae_n = 1'b1;
    tick(1);
    rx_ae_n = 1'b0;
    chk(!rx_armed, "R6 trigger disarms", int'(rx_armed), 0);
    wait_all();
    chk(n_done == d0 + 1, "R2 one done per packet", n_done - d0, 1);
    chk(n_rd == PKT, "R3 fifo pops per packet", n_rd, PKT);
    chk(rx_armed, "R11 re-armed at completion", int'(rx_armed), 1);

    // R4 R5 R8: transmit decrement from idle
    expect_xfer(12'h200, 1'b1, 1'b0);
    pulse_tx(12'h200, 1'b1);
    wait_all();

    // R8 R12: no room -> queued, served when room appears
    tx_af_n = 1'b0;
    pulse_tx(12'h300, 1'b0);
    tick(10);
    chk(!mem_req && t_idx == n_exp, "R8 no start without room", int'(mem_req), 0);
    expect_xfer(12'h300, 1'b0, 1'b0);
    tx_af_n = 1'b1;
    wait_all();

    // R7 R10 R11: park a receive and queue two transmits during a transfer
    expect_xfer(12'h400, 1'b0, 1'b0);
    expect_xfer(12'h500, 1'b1, 1'b1);
    expect_xfer(12'h600, 1'b0, 1'b0);
    expect_xfer(12'h610, 1'b1, 1'b0);
    pulse_tx(12'h400, 1'b0);
    rx_dst = 12'h500; rx_dec = 1'b1; rx_ae_n = 1'b1;
    tick(1);
    rx_ae_n = 1'b0; rx_dst = 12'h0AA;
    chk(!rx_armed && t_idx == 0 + 3, "R7 trigger parked", int'(rx_armed), 0);
    pulse_tx(12'h600, 1'b0);
    pulse_tx(12'h610, 1'b1);
    wait_all();
    chk(rx_armed, "R11 re-armed after drained queue", int'(rx_armed), 1);

    // R9: overflow of the four-entry ring
    tx_af_n = 1'b0;
    for (int i = 0; i < 5; i++) pulse_tx(12'h700 + AW'(16 * i), 1'b0);
    tick(2);
    chk(n_ovf == 1, "R9 single overflow pulse", n_ovf, 1);
    chk(!mem_req, "R9 nothing started", int'(mem_req), 0);
    for (int i = 0; i < 4; i++) expect_xfer(12'h700 + AW'(16 * i), 1'b0, 1'b0);
    tx_af_n = 1'b1;
    wait_all();

    // R10: new packet ready at completion beats queued work
    expect_xfer(12'h900, 1'b0, 1'b1);
    expect_xfer(12'h950, 1'b0, 1'b1);
    d0 = n_done;
    rx_dst = 12'h900; rx_dec = 1'b0; rx_ae_n = 1'b1;
    tick(1);
    rx_dst = 12'h950;
    begin
      int g = 0;
      while (n_done == d0 && g < 2000) begin tick(1); g++; end
    end
    tick(1);
    rx_ae_n = 1'b0;
    wait_all();
    chk(n_done == d0 + 2, "R10 two receives back to back", n_done - d0, 2);

    // R2 R5 R8: random stalls, bases and directions
    for (int it = 0; it < 20; it++) begin
      int k;
      ack_pct = 30 + int'($urandom % 71);
      k = 1 + int'($urandom % 3);
      d0 = n_done;
      for (int j = 0; j < k; j++) begin
        logic [AW-1:0] a;
        bit d;
        a = AW'($urandom);
        d = 1'($urandom);
        expect_xfer(a, d, 1'b0);
        pulse_tx(a, d);
      end
      wait_all();
      chk(n_done == d0 + k, "R2 random done count", n_done - d0, k);
      if (n_exp > 56) begin n_exp = 0; t_idx = 0; end
    end
    finish_up();
  end
endmodule